// File: doc/BRIEF.md
# PWM with Binary Rate Multiplier

This block drives a small group of output pins whose average level follows an 8-bit code per channel, so that an external RC filter turns each pin into a coarse DAC. A pulse of programmable length starts every cycle of 32 ticks. Over each frame of 8 such cycles, a few of those pulses are lengthened by one tick. This gives 256 distinct average levels while the output still repeats at the rate of the 5-bit pulse.

All channels share one prescaler and one set of cycle and frame counters. A 2-bit select picks the tick rate as the system clock divided by 2, 4, 8 or 16. Each channel holds a working copy of its code. The copy is refreshed only when a frame ends, so software may rewrite the code input at any time without producing a truncated or doubled pulse. A per-channel enable holds the pin low without stopping the shared timing.

Top module: `pwmbrm_top`

## Requirements
- R1: While reset is asserted every pin is low. All counters and working codes clear to zero, so every pin stays low for the whole first frame after reset is released.
- R2: A tick occurs once every 2^(clkSel+1) system clocks. Select codes 0, 1, 2 and 3 give divisors of 2, 4, 8 and 16.
- R3: Tick index 0..31 advances on every tick and wraps to 0, and the cycle index then advances. A frame is 8 cycles, with cycles numbered 0 to 7.
- R4: Within a cycle, the pin is high at tick indices below the width field, code bits [7:3], and low at the rest.
- R5: Code bits [2:0] add one tick of high time, directly after the width portion, in chosen cycles. Bit 2 acts in cycles 1, 3, 5 and 7, bit 1 in cycles 2 and 6, and bit 0 in cycle 4. The number of lengthened cycles per frame therefore equals the 3-bit value.
- R6: A width of 0 with no extra bits gives a pin that is always low. A width of 31 gives a pin that is high for the whole cycle in every lengthened cycle.
- R7: A channel samples its code input only at the boundary where a frame ends. A change made mid-frame has no effect on the pin until the following frame begins.
- R8: A channel whose enable is 0 drives its pin low from the next clock onward. The shared counters keep running, so re-enabling resumes in step with the frame.
- R9: The pin is registered. It reflects the counter state one system clock after the tick that produced that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkSel | input | SEL_W | Tick rate select, divisor 2^(clkSel+1) |
| chanData | input | NUM_CH*8 | Per-channel code, channel i at bits [8i+7:8i] |
| portEn | input | NUM_CH | Per-channel pin enable |
| pwmOut | output | NUM_CH | Channel pins |

## Verification
The bench builds the block with its defaults: four channels and a 2-bit select. This makes all four divisors reachable, so the longest frame (4096 clocks at divisor 16) is run in full. Four channels let one run place a zero width, a full width, a pure width and each single extra-pulse bit side by side. The bench holds its own model of the tick and frame position. With that model it compares every pin on every clock, which covers the exact cycles picked by each extra-pulse bit, mid-frame code writes and enable changes at arbitrary clocks.

// File: rtl/pwmbrm_pkg.sv
package pwmbrm_pkg;

  localparam int PWM_BITS  = 5;
  localparam int BRM_BITS  = 3;
  localparam int CODE_BITS = PWM_BITS + BRM_BITS;

  // Timing state handed from the control to every channel datapath
  typedef struct packed {
    logic                frameEnd;
    logic [PWM_BITS-1:0] tickIdx;
    logic [BRM_BITS-1:0] cycleIdx;
  } pwmStrobes_t;

  // Rate-multiplier selection: code bit k acts in the cycles whose lowest
  // set bit sits at position BRM_BITS-1-k
  function automatic logic brmHit(input logic [BRM_BITS-1:0] cyc,
                                  input logic [BRM_BITS-1:0] rate);
    logic                hit;
    logic [BRM_BITS-1:0] lowMask;
    logic [BRM_BITS-1:0] leadBit;
    hit = 1'b0;
    for (int k = 0; k < BRM_BITS; k++) begin
      lowMask = BRM_BITS'((1 << (BRM_BITS - k)) - 1);
      leadBit = BRM_BITS'(1 << (BRM_BITS - 1 - k));
      if (rate[k] && ((cyc & lowMask) == leadBit)) hit = 1'b1;
    end
    return hit;
  endfunction

endpackage

// File: rtl/pwmbrm_ctrl.sv
module pwmbrm_ctrl
  import pwmbrm_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] clkSel,
  output pwmStrobes_t      strb
);

  localparam int DIV_W = 1 << SEL_W;

  logic [DIV_W-1:0]    prescCnt;
  logic [DIV_W-1:0]    divLimit;
  logic                tick;
  logic [PWM_BITS-1:0] tickCnt;
  logic [BRM_BITS-1:0] cycleCnt;
  logic                lastTick;
  logic                lastCycle;

  always_comb begin
    divLimit = DIV_W'((64'd1 << (int'(clkSel) + 1)) - 64'd1);
  end

  // A shrinking select never strands the counter above the limit
  assign tick      = (prescCnt >= divLimit);
  assign lastTick  = (tickCnt == '1);
  assign lastCycle = (cycleCnt == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescCnt <= '0;
    end else if (tick) begin
      prescCnt <= '0;
    end else begin
      prescCnt <= prescCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt  <= '0;
      cycleCnt <= '0;
    end else if (tick) begin
      tickCnt <= tickCnt + 1'b1;
      if (lastTick) cycleCnt <= cycleCnt + 1'b1;
    end
  end

  always_comb begin
    strb.frameEnd = tick & lastTick & lastCycle;
    strb.tickIdx  = tickCnt;
    strb.cycleIdx = cycleCnt;
  end

endmodule

// File: rtl/pwmbrm_chan.sv
module pwmbrm_chan
  import pwmbrm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  pwmStrobes_t          strb,
  input  logic [CODE_BITS-1:0] dataIn,
  input  logic                 enable,
  output logic                 pinOut,
  output logic [CODE_BITS-1:0] activeOut
);

  logic [CODE_BITS-1:0] activeVal;
  logic [PWM_BITS-1:0]  widthVal;
  logic [BRM_BITS-1:0]  rateVal;
  logic                 extraTick;
  logic [PWM_BITS:0]    highSpan;
  logic                 highNow;

  // Working copy refreshed only on the frame boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeVal <= '0;
    end else if (strb.frameEnd) begin
      activeVal <= dataIn;
    end
  end

  assign widthVal  = activeVal[CODE_BITS-1:BRM_BITS];
  assign rateVal   = activeVal[BRM_BITS-1:0];
  assign extraTick = brmHit(strb.cycleIdx, rateVal);
  assign highSpan  = {1'b0, widthVal} + (PWM_BITS+1)'(extraTick);
  assign highNow   = ({1'b0, strb.tickIdx} < highSpan);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinOut <= 1'b0;
    end else begin
      pinOut <= highNow & enable;
    end
  end

  assign activeOut = activeVal;

endmodule

// File: rtl/pwmbrm_top.sv
module pwmbrm_top
  import pwmbrm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SEL_W  = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [SEL_W-1:0]            clkSel,
  input  logic [NUM_CH*CODE_BITS-1:0] chanData,
  input  logic [NUM_CH-1:0]           portEn,
  output logic [NUM_CH-1:0]           pwmOut
);

  pwmStrobes_t                 strb;
  logic [NUM_CH*CODE_BITS-1:0] activeBus;

  pwmbrm_ctrl #(.SEL_W(SEL_W)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .clkSel (clkSel),
    .strb   (strb)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    pwmbrm_chan chan_i (
      .clk       (clk),
      .rstN      (rstN),
      .strb      (strb),
      .dataIn    (chanData[ch*CODE_BITS +: CODE_BITS]),
      .enable    (portEn[ch]),
      .pinOut    (pwmOut[ch]),
      .activeOut (activeBus[ch*CODE_BITS +: CODE_BITS])
    );
  end

endmodule

// File: rtl/pwmbrm_chk.sv
module pwmbrm_chk
  import pwmbrm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SEL_W  = 2
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [SEL_W-1:0]            clkSel,
  input logic [NUM_CH-1:0]           portEn,
  input logic [NUM_CH-1:0]           pwmOut,
  input pwmStrobes_t                 strb,
  input logic [NUM_CH*CODE_BITS-1:0] activeBus
);

  logic [7:0]          gapCnt;
  logic [PWM_BITS-1:0] prevIdx;
  logic [SEL_W-1:0]    prevSel;
  logic                selHeld;
  logic                idxMoved;

  assign idxMoved = (strb.tickIdx != prevIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt  <= '0;
      prevIdx <= '0;
      prevSel <= '0;
      selHeld <= 1'b1;
    end else begin
      prevIdx <= strb.tickIdx;
      prevSel <= clkSel;
      if (idxMoved) begin
        gapCnt  <= 8'd1;
        selHeld <= 1'b1;
      end else begin
        gapCnt <= gapCnt + 8'd1;
        if (clkSel != prevSel) selHeld <= 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (pwmOut == '0) else $error("pins active in reset"); // R1
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (idxMoved && selHeld) |-> (gapCnt == 8'(1 << (int'(clkSel) + 1)))); // R2

  AST_CYCLE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tickIdx == '1) |=> ((strb.tickIdx == '1) ||
      ((strb.tickIdx == '0) && (strb.cycleIdx == BRM_BITS'($past(strb.cycleIdx) + 1'b1))))); // R3

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChk
    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rstN)
      !portEn[ch] |=> !pwmOut[ch]); // R8

    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !strb.frameEnd |=> $stable(activeBus[ch*CODE_BITS +: CODE_BITS])); // R7

    AST_ZERO_CODE: assert property (@(posedge clk) disable iff (!rstN)
      (activeBus[ch*CODE_BITS +: CODE_BITS] == '0) |=> !pwmOut[ch]); // R6
  end

endmodule

bind pwmbrm_top pwmbrm_chk #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .clkSel    (clkSel),
  .portEn    (portEn),
  .pwmOut    (pwmOut),
  .strb      (strb),
  .activeBus (activeBus)
);

// File: tb/pwmbrm_top_tb_top.sv
`timescale 1ns/1ps
module pwmbrm_top_tb_top;

  localparam int NUM_CH = 4;
  localparam int SEL_W  = 2;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic [SEL_W-1:0]     clkSel = '0;
  logic [NUM_CH*8-1:0]  chanData = '0;
  logic [NUM_CH-1:0]    portEn = '0;
  logic [NUM_CH-1:0]    pwmOut;

  int checks = 0;
  int errors = 0;
  int k = 0;
  logic [NUM_CH-1:0]   enS = '0;
  logic [NUM_CH*8-1:0] frameData [0:63];
  int   mism   [NUM_CH];
  int   firstK [NUM_CH];
  logic firstA [NUM_CH];
  logic firstE [NUM_CH];

  always #2 clk = ~clk;

  pwmbrm_top #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) dut_i (
    .clk(clk), .rstN(rstN), .clkSel(clkSel),
    .chanData(chanData), .portEn(portEn), .pwmOut(pwmOut)
  );

  function automatic int divisor();
    return 1 << (int'(clkSel) + 1);
  endfunction

  function automatic int frameLen();
    return 256 * divisor();
  endfunction

  function automatic logic [7:0] code(input int w, input int b);
    return {5'(w), 3'(b)};
  endfunction

  // Bench model of frame-boundary sampling (R7) and registered enable (R8)
  always @(posedge clk) begin
    if (!rstN) begin
      k <= 0;
      frameData[0] <= '0;
    end else begin
      k <= k + 1;
      if (((k + 1) % frameLen()) == 0 && ((k + 1) / frameLen()) < 64)
        frameData[(k + 1) / frameLen()] <= chanData;
    end
    enS <= portEn;
  end

  // Expected pin level from R2..R6, R8, R9
  function automatic logic expPin(input int ch);
    int g, t, c, f, w, extra;
    logic [7:0] d;
    if (k < 1) return 1'b0;
    g = (k - 1) / divisor();
    t = g % 32;
    c = (g / 32) % 8;
    f = g / 256;
    d = frameData[f][ch*8 +: 8];
    w = int'(d[7:3]);
    extra = ((d[2] && (c % 2 == 1)) || (d[1] && (c % 4 == 2)) || (d[0] && c == 4)) ? 1 : 0;
    return enS[ch] && (t < w + extra);
  endfunction

  task automatic runSpan(input int n);
    logic e;
    repeat (n) begin
      @(negedge clk);
      for (int ch = 0; ch < NUM_CH; ch++) begin
        e = expPin(ch);
        if (pwmOut[ch] !== e) begin
          if (mism[ch] == 0) begin
            firstK[ch] = k; firstA[ch] = pwmOut[ch]; firstE[ch] = e;
          end
          mism[ch]++;
        end
      end
    end
  endtask

  task automatic checkChannels(input string tag);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      checks++;
      if (mism[ch] != 0) begin
        errors++;
        $display("FAIL %s ch%0d: %0d bad clocks, first at clock %0d actual %b expected %b",
                 tag, ch, mism[ch], firstK[ch], firstA[ch], firstE[ch]);
      end
      mism[ch] = 0;
    end
  endtask

  task automatic doReset(input logic [SEL_W-1:0] sel, input logic [NUM_CH*8-1:0] d,
                         input logic [NUM_CH-1:0] en);
    rstN = 1'b0;
    clkSel = sel; chanData = d; portEn = en;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (pwmOut !== '0) begin
      errors++;
      $display("FAIL R1 pins in reset: actual %b expected 0000", pwmOut);
    end
    @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  // R1: quiet reset and an all-low first frame
  task automatic testResetState();
    doReset(2'd0, {code(31,7), code(16,0), code(1,1), code(5,4)}, '1);
    runSpan(frameLen());
    checkChannels("R1 first frame low");
  endtask

  // R4, R6: pure widths including both extremes, R9 clock alignment
  task automatic testWidths();
    doReset(2'd0, {code(31,0), code(17,0), code(5,0), code(0,0)}, '1);
    runSpan(2 * frameLen());
    checkChannels("R4 R6 R9 width only");
  endtask

  // R5, R6: each extra-pulse bit alone, and all bits on a full width
  task automatic testRateBits();
    doReset(2'd0, {code(31,7), code(3,4), code(3,2), code(3,1)}, '1);
    runSpan(2 * frameLen());
    checkChannels("R5 R6 rate bits");
  endtask

  // R2, R3: every divisor over a full active frame
  task automatic testPrescaler();
    for (int s = 1; s < 4; s++) begin
      doReset(SEL_W'(s), {code(0,3), code(9,5), code(30,6), code(12,7)}, '1);
      runSpan(2 * frameLen());
      checkChannels($sformatf("R2 R3 divisor sel=%0d", s));
    end
  endtask

  // R7: a mid-frame write waits for the next frame boundary
  task automatic testMidFrameWrite();
    doReset(2'd0, {code(4,1), code(8,2), code(2,4), code(20,0)}, '1);
    runSpan(frameLen() + 137);
    @(posedge clk); #1 chanData = {code(25,6), code(0,0), code(31,7), code(1,3)};
    runSpan(frameLen() - 200);
    checkChannels("R7 old code holds to frame end");
    runSpan(frameLen());
    checkChannels("R7 new code in next frame");
  endtask

  // R8: enable gating mid-frame with counters running on
  task automatic testEnable();
    doReset(2'd0, {code(10,5), code(31,7), code(6,2), code(15,1)}, '1);
    runSpan(frameLen() + 301);
    @(posedge clk); #1 portEn = 4'b0101;
    runSpan(frameLen() / 2 + 13);
    @(posedge clk); #1 portEn = 4'b1010;
    runSpan(frameLen() / 2);
    @(posedge clk); #1 portEn = 4'b1111;
    runSpan(frameLen());
    checkChannels("R8 enable gating");
  endtask

  initial begin
    for (int ch = 0; ch < NUM_CH; ch++) begin
      mism[ch] = 0; firstK[ch] = 0; firstA[ch] = 1'b0; firstE[ch] = 1'b0;
    end
    testResetState();
    testWidths();
    testRateBits();
    testPrescaler();
    testMidFrameWrite();
    testEnable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule